// File: doc/BRIEF.md
# Optimistic Coherence Resolution Controller

This block sequences one accelerator kernel that runs optimistically against concurrent CPU threads. While the kernel runs, the accelerator behaves as if it already holds coherence permission, and the controller issues no coherence traffic. Coherence is examined only once, after the kernel reports completion. At that point the controller samples a single conflict flag. The signature units outside this block raise that flag only when the CPU write set overlaps the accelerator read set.

With no conflict, the controller starts two cleanup requests at the same time. One asks the accelerator to commit its buffered updates. The other asks the CPU side to invalidate clean lines that hit in the accelerator write set. When both are acknowledged, it returns to idle and pulses a completion strobe. With a conflict, it first asks the CPU side to flush dirty lines that hit in the accelerator read set. It then asks the accelerator to drop its uncommitted lines. Finally, for one cycle, it clears the signatures and restarts the kernel, and it counts the abort. CPU threads are never stalled by this block. Every cleanup action is a request held high until a one-cycle acknowledge.

Top module: `optc_top`

## Requirements
- R1: After reset, runActive, every request output, sigClear, kernelRestart and commitDone are 0, and abortCount is 0.
- R2: kernelStart sampled in idle makes runActive 1 from the next cycle. kernelStart sampled in any other state has no effect.
- R3: While runActive is 1, flushReq, discardReq, commitReq and cpuInvReq are all 0. kernelDone sampled in idle has no effect.
- R4: kernelDone sampled while running leads to one check cycle with no requests. If conflictIn is 0 in that check cycle, commitReq and cpuInvReq both rise in the following cycle and flushReq stays 0.
- R5: If conflictIn is 1 in the check cycle, flushReq rises in the following cycle. discardReq rises only in the cycle after flushAck is sampled, and flushReq falls in that same cycle.
- R6: Each request stays 1 until its acknowledge is sampled and is 0 from the next cycle. An acknowledge sampled while its request is 0 has no effect.
- R7: The cycle after discardAck is sampled, sigClear and kernelRestart are 1 for exactly one cycle. After that, runActive is 1 again without a new kernelStart.
- R8: abortCount rises by one per restart, visible in the cycle after the restart pulse. It saturates at all ones and is cleared only by reset.
- R9: commitDone is 1 for exactly one cycle, in the cycle after the later of commitAck and cpuInvAck is sampled, and the controller is idle in that cycle.
- R10: conflictIn has no effect outside the check cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kernelStart | input | 1 | Launch request for the kernel |
| kernelDone | input | 1 | Kernel completion pulse |
| conflictIn | input | 1 | Read-set / CPU-write-set overlap flag from the signature units |
| commitAck | input | 1 | Accelerator commit acknowledge |
| cpuInvAck | input | 1 | CPU clean-line invalidate acknowledge |
| flushAck | input | 1 | CPU dirty-line flush acknowledge |
| discardAck | input | 1 | Accelerator uncommitted-data discard acknowledge |
| runActive | output | 1 | Kernel running in optimistic mode |
| commitReq | output | 1 | Commit accelerator updates |
| cpuInvReq | output | 1 | Invalidate CPU clean lines hitting the write set |
| flushReq | output | 1 | Flush CPU dirty lines hitting the read set |
| discardReq | output | 1 | Discard uncommitted accelerator lines |
| sigClear | output | 1 | One-cycle signature clear |
| kernelRestart | output | 1 | One-cycle kernel re-execution pulse |
| commitDone | output | 1 | One-cycle commit completion pulse |
| abortCount | output | CNT_W | Saturating count of aborts since reset |

## Verification
Two situations are hard to reach from the ports. The first is saturation of the abort counter, which needs a long run of back-to-back conflicting kernels. The bench narrows the counter parameter and repeats the full abort sequence until the count pins at its maximum. The second is acknowledges that arrive at the wrong moment: early, out of order, or simultaneous. The bench sends stray acknowledges in idle and during a flush, sends the two commit-path acknowledges in both orders and together, and keeps conflictIn high during the run so that the check cycle is the only point where the flag can act.

// File: rtl/optc_pkg.sv
`timescale 1ns/1ps
package optc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RUN, S_CHECK, S_COMMIT, S_FLUSH, S_DISCARD, S_RESTART
  } ctrlState_t;

  typedef struct packed {
    logic inCommit;
    logic inFlush;
    logic inDiscard;
    logic clearGot;
    logic bumpAbort;
    logic pulseDone;
  } dpStrobe_t;

  localparam int COMMIT_AGENTS = 2;
endpackage

// File: rtl/optc_ctrl.sv
`timescale 1ns/1ps
module optc_ctrl
  import optc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kernelStart,
  input  logic       kernelDone,
  input  logic       conflictIn,
  input  logic       flushAck,
  input  logic       discardAck,
  input  logic       commitAllDone,
  output dpStrobe_t  strobe,
  output logic       runActive,
  output logic       sigClear,
  output logic       kernelRestart
);
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:    if (kernelStart) stateNext = S_RUN;
      S_RUN:     if (kernelDone) stateNext = S_CHECK;
      S_CHECK:   stateNext = conflictIn ? S_FLUSH : S_COMMIT;
      S_COMMIT:  if (commitAllDone) stateNext = S_IDLE;
      S_FLUSH:   if (flushAck) stateNext = S_DISCARD;
      S_DISCARD: if (discardAck) stateNext = S_RESTART;
      S_RESTART: stateNext = S_RUN;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.inCommit  = (state == S_COMMIT);
    strobe.inFlush   = (state == S_FLUSH);
    strobe.inDiscard = (state == S_DISCARD);
    strobe.clearGot  = (state == S_CHECK);
    strobe.bumpAbort = (state == S_RESTART);
    strobe.pulseDone = (state == S_COMMIT) && commitAllDone;
  end

  assign runActive     = (state == S_RUN);
  assign sigClear      = (state == S_RESTART);
  assign kernelRestart = (state == S_RESTART);

  // R2: a start outside idle never changes the state
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_RUN && kernelStart && state != S_COMMIT && state != S_CHECK
     && !flushAck && !discardAck) |=> $stable(state) || state == S_RUN);
  // R4: the check cycle lasts exactly one cycle
  p_check_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK) |=> (state == S_COMMIT || state == S_FLUSH));
endmodule

// File: rtl/optc_dp.sv
`timescale 1ns/1ps
module optc_dp
  import optc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             commitAck,
  input  logic             cpuInvAck,
  output logic             commitReq,
  output logic             cpuInvReq,
  output logic             flushReq,
  output logic             discardReq,
  output logic             commitAllDone,
  output logic             commitDone,
  output logic [CNT_W-1:0] abortCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [COMMIT_AGENTS-1:0] ackVec, gotVec, reqVec, doneVec;
  assign ackVec = {cpuInvAck, commitAck};

  for (genvar g = 0; g < COMMIT_AGENTS; g++) begin : g_agent
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearGot)              gotVec[g] <= 1'b0;
      else if (strobe.inCommit && ackVec[g])     gotVec[g] <= 1'b1;
    end
    assign reqVec[g]  = strobe.inCommit && !gotVec[g];
    assign doneVec[g] = gotVec[g] || ackVec[g];
  end

  assign commitReq     = reqVec[0];
  assign cpuInvReq     = reqVec[1];
  assign commitAllDone = strobe.inCommit && (&doneVec);
  assign flushReq      = strobe.inFlush;
  assign discardReq    = strobe.inDiscard;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortCount <= '0;
      commitDone <= 1'b0;
    end else begin
      commitDone <= strobe.pulseDone;
      if (strobe.bumpAbort && abortCount != CNT_MAX)
        abortCount <= abortCount + 1'b1;
    end
  end

  // R6: a request waits for its acknowledge
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (commitReq && !commitAck) |=> commitReq);
  // R8: each restart moves the counter by one or leaves it pinned at max
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpAbort |=> (abortCount == CNT_W'($past(abortCount) + 1'b1))
                      || (abortCount == CNT_MAX && $past(abortCount) == CNT_MAX));
  // R9: completion strobe is a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone);
endmodule

// File: rtl/optc_top.sv
`timescale 1ns/1ps
module optc_top
  import optc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kernelStart,
  input  logic             kernelDone,
  input  logic             conflictIn,
  input  logic             commitAck,
  input  logic             cpuInvAck,
  input  logic             flushAck,
  input  logic             discardAck,
  output logic             runActive,
  output logic             commitReq,
  output logic             cpuInvReq,
  output logic             flushReq,
  output logic             discardReq,
  output logic             sigClear,
  output logic             kernelRestart,
  output logic             commitDone,
  output logic [CNT_W-1:0] abortCount
);
  dpStrobe_t strobe;
  logic      commitAllDone;

  optc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .kernelStart(kernelStart), .kernelDone(kernelDone),
    .conflictIn(conflictIn), .flushAck(flushAck), .discardAck(discardAck),
    .commitAllDone(commitAllDone), .strobe(strobe), .runActive(runActive),
    .sigClear(sigClear), .kernelRestart(kernelRestart)
  );

  optc_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .commitAck(commitAck),
    .cpuInvAck(cpuInvAck), .commitReq(commitReq), .cpuInvReq(cpuInvReq),
    .flushReq(flushReq), .discardReq(discardReq), .commitAllDone(commitAllDone),
    .commitDone(commitDone), .abortCount(abortCount)
  );

  // R3: optimistic run issues no cleanup traffic
  p_quiet_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    runActive |-> !(flushReq || discardReq || commitReq || cpuInvReq));
  // R5: discard follows an acknowledged flush
  p_flush_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(discardReq) |-> $past(flushReq && flushAck));
  // R7: restart pulse leads straight back into the run
  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    kernelRestart |=> (runActive && !kernelRestart && !sigClear));
endmodule

// File: tb/test_optc_top.sv
`timescale 1ns/1ps
module test_optc_top;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic kernelStart = 0, kernelDone = 0, conflictIn = 0;
  logic commitAck = 0, cpuInvAck = 0, flushAck = 0, discardAck = 0;
  logic runActive, commitReq, cpuInvReq, flushReq, discardReq;
  logic sigClear, kernelRestart, commitDone;
  logic [CW-1:0] abortCount;

  int total = 0, bad = 0, modelAborts = 0;
  int expQ[$];

  always #4 clk = ~clk;

  optc_top #(.CNT_W(CW)) i_optc_top (
    .clk(clk), .rstN(rstN), .kernelStart(kernelStart), .kernelDone(kernelDone),
    .conflictIn(conflictIn), .commitAck(commitAck), .cpuInvAck(cpuInvAck),
    .flushAck(flushAck), .discardAck(discardAck), .runActive(runActive),
    .commitReq(commitReq), .cpuInvReq(cpuInvReq), .flushReq(flushReq),
    .discardReq(discardReq), .sigClear(sigClear), .kernelRestart(kernelRestart),
    .commitDone(commitDone), .abortCount(abortCount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int reqs();
    return {flushReq, discardReq, commitReq, cpuInvReq};
  endfunction

  // scoreboard monitor: each commit completion must match a queued item
  always @(negedge clk) begin
    if (rstN && commitDone) begin
      if (expQ.size() == 0) chk(0, "R9 unexpected commitDone", 1, 0);
      else begin
        int e;
        e = expQ.pop_front();
        chk(abortCount == e, "R9 abortCount at commit", abortCount, e);
      end
    end
  end

  task automatic startKernel();
    @(negedge clk); kernelStart = 1;
    @(negedge clk); kernelStart = 0;
    chk(runActive == 1, "R2 run after start", runActive, 1);
  endtask

  task automatic finishRun(input bit conflict);
    @(negedge clk); kernelDone = 1; conflictIn = conflict;
    @(negedge clk); kernelDone = 0;
    chk(runActive == 0 && reqs() == 0, "R4 check cycle quiet", reqs(), 0);
    @(negedge clk); conflictIn = 0;
  endtask

  // mode 0: commit ack first, 1: invalidate ack first, 2: both together
  task automatic doCommit(input int mode);
    expQ.push_back(modelAborts);
    finishRun(0);
    chk(commitReq && cpuInvReq && !flushReq, "R4 commit path reqs", reqs(), 3);
    @(negedge clk);
    chk(commitReq && cpuInvReq, "R6 reqs held", reqs(), 3);
    if (mode == 2) begin commitAck = 1; cpuInvAck = 1; end
    else if (mode == 0) commitAck = 1;
    else cpuInvAck = 1;
    @(negedge clk); commitAck = 0; cpuInvAck = 0;
    if (mode != 2) begin
      chk(commitReq == (mode == 1) && cpuInvReq == (mode == 0), "R6 one req dropped",
          reqs(), mode == 0 ? 1 : 2);
      chk(commitDone == 0, "R9 no done with one ack", commitDone, 0);
      @(negedge clk);
      if (mode == 0) cpuInvAck = 1; else commitAck = 1;
      @(negedge clk); commitAck = 0; cpuInvAck = 0;
    end
    chk(commitDone == 1 && runActive == 0 && reqs() == 0, "R9 done pulse idle", commitDone, 1);
    @(negedge clk);
    chk(commitDone == 0, "R9 done one cycle", commitDone, 0);
  endtask

  task automatic doAbort();
    finishRun(1);
    chk(flushReq && !discardReq && !commitReq, "R5 flush first", reqs(), 8);
    discardAck = 1;
    @(negedge clk); discardAck = 0;
    chk(flushReq && !discardReq, "R6 stray discardAck ignored", reqs(), 8);
    flushAck = 1;
    @(negedge clk); flushAck = 0;
    chk(!flushReq && discardReq, "R5 discard after flush", reqs(), 4);
    discardAck = 1;
    @(negedge clk); discardAck = 0;
    chk(sigClear && kernelRestart && !runActive, "R7 restart pulse", kernelRestart, 1);
    if (modelAborts < CMAX) modelAborts++;
    @(negedge clk);
    chk(runActive && !kernelRestart && !sigClear, "R7 re-executing", runActive, 1);
    chk(abortCount == modelAborts, "R8 abort count", abortCount, modelAborts);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(runActive == 0 && reqs() == 0 && !sigClear && !kernelRestart && !commitDone,
        "R1 reset outputs", reqs(), 0);
    chk(abortCount == 0, "R1 reset count", abortCount, 0);
    // R3: done pulse in idle, R6: stray acks in idle
    kernelDone = 1; commitAck = 1; cpuInvAck = 1; flushAck = 1;
    @(negedge clk); kernelDone = 0; commitAck = 0; cpuInvAck = 0; flushAck = 0;
    @(negedge clk);
    chk(runActive == 0 && reqs() == 0 && !commitDone, "R3 idle done ignored", reqs(), 0);
    // R10: conflict during run has no effect, R2: start during run ignored
    startKernel();
    conflictIn = 1; kernelStart = 1;
    repeat (3) @(negedge clk);
    chk(runActive && reqs() == 0, "R10 R3 quiet run with conflict high", reqs(), 0);
    conflictIn = 0; kernelStart = 0;
    doCommit(0);
    // R2: start during the commit path does nothing
    startKernel();
    expQ.push_back(modelAborts);
    finishRun(0);
    kernelStart = 1;
    @(negedge clk); kernelStart = 0;
    chk(commitReq && cpuInvReq && !runActive, "R2 start ignored in commit", reqs(), 3);
    commitAck = 1; cpuInvAck = 1;
    @(negedge clk); commitAck = 0; cpuInvAck = 0;
    chk(commitDone && !runActive, "R9 done after both acks", commitDone, 1);
    // abort then commit with other ack orders
    startKernel();
    doAbort();
    doCommit(1);
    startKernel();
    doAbort();
    doCommit(2);
    // R8: saturation
    startKernel();
    for (int i = 0; i < CMAX + 2; i++) doAbort();
    chk(abortCount == CMAX, "R8 saturated", abortCount, CMAX);
    doCommit(0);
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R9 all commits seen", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule